// File: doc/BRIEF.md
# Masked Master-ID Access Filter

This block decides whether a bus transaction may proceed, based on the identity of the master that issued it. A table of twenty entries sits in a small register array. Each entry holds a 10-bit identity value, a compare mask of the same width, a read-only flag and a parity bit that software computes. A request presents an identity and a direction (read or write). The block compares that identity with every entry that the permission vector enables and that has not been disabled. Mask bits that are zero make the matching identity bits don't-care. An entry with the read-only flag set lets reads through and refuses writes. The request is allowed if any taking-part entry permits it. The decision comes back one cycle after the request.

Software programs entries through a register write port and can read them back through a registered read port. A background scanner walks the table one entry per cycle, from index 0 up to index 19 and then back to 0. When the parity check is switched on, the scanner checks each entry's even parity. An entry whose parity fails is taken out of matching, and a sticky interrupt is raised. Software clears the interrupt by pulsing a clear input. A disabled entry comes back into use only when software writes it again. Register writes have priority over the scanner: the scan pointer holds still in any cycle that carries a write.

Top module: `idFilter`

## Requirements
- R1: After reset, `respValid` and `irq` are 0, and every table entry reads back as zero.
- R2: A write to index 0..19 stores the word. A read presented in one cycle returns that word on `regRdData` in the next cycle. Bits 15:10 and 29:26 always read as zero. Writes to index 20 or above are ignored, and reads of index 20 or above return zero.
- R3: An entry holds the identity in bits 9:0 and the mask in bits 25:16. It matches when `(reqId & mask) == (id & mask)`, so a zero mask bit makes that identity bit a don't-care.
- R4: Entry i takes part in matching only while `permVec[i]` is 1. With `permVec` all zero, every request is denied.
- R5: A matched entry whose bit 30 (read-only) is set permits a read (`reqWrite`=0) and does not permit a write (`reqWrite`=1).
- R6: A request is allowed if at least one taking-part entry permits it. Otherwise it is denied.
- R7: `respValid` is 1 in exactly the cycle after a cycle with `reqValid`=1. `respAllow` gives the decision in that cycle.
- R8: With `parityEn`=1, the scanner checks each entry within 20 cycles that carry no register write. The parity bit 31 must make the XOR over bits 31, 30, 25:16 and 9:0 equal to zero. An entry that fails this check sets `irq` and stops matching. Other entries keep matching.
- R9: With `parityEn`=0, no parity check is made: `irq` stays 0 and an entry with bad parity keeps matching.
- R10: `irq` stays 1 until a cycle with `irqClr`=1. In that cycle it clears, unless a new parity error is found in the same cycle. An entry that is already disabled raises no further interrupts.
- R11: Writing an entry re-enables it. If the new word has valid parity, it matches again and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Table write strobe |
| regRdEn | input | 1 | Table read strobe |
| regAddr | input | 5 | Entry index for read or write |
| regWrData | input | 32 | Entry word to write |
| regRdData | output | 32 | Entry word read back, valid the cycle after `regRdEn` |
| permVec | input | 20 | Per-entry enable for matching |
| parityEn | input | 1 | Enables the background parity check |
| irqClr | input | 1 | Clears the sticky parity interrupt |
| irq | output | 1 | Sticky parity-error interrupt |
| reqValid | input | 1 | Transaction request strobe |
| reqId | input | 10 | Master identity of the request |
| reqWrite | input | 1 | 1 for a write transaction, 0 for a read |
| respValid | output | 1 | Decision valid, one cycle after `reqValid` |
| respAllow | output | 1 | 1 when the transaction is allowed |

## Verification
The bench builds the block with its default parameters: twenty entries and a 10-bit identity. The scan period is therefore 20 cycles, and a bench wait of about 25 cycles covers a full sweep. The valid index range ends at 19, so a write and a read at index 25 fall inside the 5-bit address but outside the table, which exercises the range check. The identity width puts the mask field at bits 25:16 with reserved gaps on both sides, so the read-back checks show that those gaps stay zero and that they are left out of the parity.

// File: rtl/idFilterPkg.sv
package idFilterPkg;
  localparam int WORD_W   = 32;
  localparam int ID_LSB   = 0;
  localparam int MASK_LSB = 16;
  localparam int RO_BIT   = 30;
  localparam int PAR_BIT  = 31;

  typedef struct packed {
    logic tableWr;
    logic tableRd;
    logic scanChk;
  } filtStrobe_t;

  function automatic logic [WORD_W-1:0] keepMask(input int idW);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int b = 0; b < idW; b++) begin
      m[ID_LSB + b]   = 1'b1;
      m[MASK_LSB + b] = 1'b1;
    end
    m[RO_BIT]  = 1'b1;
    m[PAR_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/idFilterCtrl.sv
module idFilterCtrl
  import idFilterPkg::*;
#(
  parameter int NUM_ENTRIES = 20,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [IDX_W-1:0]       regAddr,
  input  logic                   parityEn,
  input  logic                   irqClr,
  input  logic                   scanErr,
  output filtStrobe_t            strobe,
  output logic [IDX_W-1:0]       scanIdx,
  output logic [NUM_ENTRIES-1:0] disabledVec,
  output logic                   irq
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic addrInRange;
  logic errHit;

  assign addrInRange    = (regAddr <= LAST_IDX);
  assign strobe.tableWr = regWrEn && addrInRange;
  assign strobe.tableRd = regRdEn;
  assign strobe.scanChk = parityEn && !regWrEn && !disabledVec[scanIdx];
  assign errHit         = strobe.scanChk && scanErr;

  // round-robin scan pointer, holds while a write owns the table port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanIdx <= '0;
    end else if (!regWrEn) begin
      if (scanIdx == LAST_IDX) scanIdx <= '0;
      else                     scanIdx <= scanIdx + 1'b1;
    end
  end

  // disable tracking: a write re-enables, a failed check disables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disabledVec <= '0;
    end else begin
      if (strobe.tableWr) disabledVec[regAddr] <= 1'b0;
      else if (errHit)    disabledVec[scanIdx] <= 1'b1;
    end
  end

  // sticky interrupt, a new error wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       irq <= 1'b0;
    else if (errHit) irq <= 1'b1;
    else if (irqClr) irq <= 1'b0;
  end
endmodule

// File: rtl/idFilterDp.sv
module idFilterDp
  import idFilterPkg::*;
#(
  parameter int NUM_ENTRIES = 20,
  parameter int ID_W = 10,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  filtStrobe_t            strobe,
  input  logic [IDX_W-1:0]       regAddr,
  input  logic [WORD_W-1:0]      regWrData,
  output logic [WORD_W-1:0]      regRdData,
  input  logic [IDX_W-1:0]       scanIdx,
  output logic                   scanErr,
  input  logic [NUM_ENTRIES-1:0] permVec,
  input  logic [NUM_ENTRIES-1:0] disabledVec,
  input  logic                   reqValid,
  input  logic [ID_W-1:0]        reqId,
  input  logic                   reqWrite,
  output logic                   respValid,
  output logic                   respAllow
);
  localparam logic [WORD_W-1:0] KEEP     = keepMask(ID_W);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [WORD_W-1:0]      tableMem [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tableMem[i] <= '0;
    end else if (strobe.tableWr) begin
      tableMem[regAddr] <= regWrData & KEEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (strobe.tableRd) begin
      if (regAddr <= LAST_IDX) regRdData <= tableMem[regAddr];
      else                     regRdData <= '0;
    end
  end

  // odd XOR over covered bits (parity bit included) flags an error
  assign scanErr = ^(tableMem[scanIdx] & KEEP);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic [ID_W-1:0] entId;
    logic [ID_W-1:0] entMask;
    logic            entRo;
    logic            idMatch;
    assign entId   = tableMem[g][ID_LSB +: ID_W];
    assign entMask = tableMem[g][MASK_LSB +: ID_W];
    assign entRo   = tableMem[g][RO_BIT];
    assign idMatch = ((reqId ^ entId) & entMask) == '0;
    assign hitVec[g] = permVec[g] && !disabledVec[g] && idMatch
                       && !(entRo && reqWrite);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respAllow <= 1'b0;
    end else begin
      respValid <= reqValid;
      respAllow <= reqValid && (|hitVec);
    end
  end
endmodule

// File: rtl/idFilter.sv
module idFilter
  import idFilterPkg::*;
#(
  parameter int NUM_ENTRIES = 20,
  parameter int ID_W = 10,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [IDX_W-1:0]       regAddr,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  input  logic [NUM_ENTRIES-1:0] permVec,
  input  logic                   parityEn,
  input  logic                   irqClr,
  output logic                   irq,
  input  logic                   reqValid,
  input  logic [ID_W-1:0]        reqId,
  input  logic                   reqWrite,
  output logic                   respValid,
  output logic                   respAllow
);
  filtStrobe_t            strobe;
  logic [IDX_W-1:0]       scanIdx;
  logic [NUM_ENTRIES-1:0] disabledVec;
  logic                   scanErr;

  idFilterCtrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .parityEn(parityEn), .irqClr(irqClr),
    .scanErr(scanErr), .strobe(strobe), .scanIdx(scanIdx),
    .disabledVec(disabledVec), .irq(irq)
  );

  idFilterDp #(.NUM_ENTRIES(NUM_ENTRIES), .ID_W(ID_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .scanIdx(scanIdx),
    .scanErr(scanErr), .permVec(permVec), .disabledVec(disabledVec),
    .reqValid(reqValid), .reqId(reqId), .reqWrite(reqWrite),
    .respValid(respValid), .respAllow(respAllow)
  );
endmodule

// File: rtl/idFilterChk.sv
module idFilterChk #(
  parameter int NUM_ENTRIES = 20,
  parameter int IDX_W = 5
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   regWrEn,
  input logic [IDX_W-1:0]       regAddr,
  input logic [NUM_ENTRIES-1:0] permVec,
  input logic                   parityEn,
  input logic                   irqClr,
  input logic                   irq,
  input logic                   reqValid,
  input logic                   respValid,
  input logic                   respAllow,
  input logic [IDX_W-1:0]       scanIdx,
  input logic [NUM_ENTRIES-1:0] disabledVec
);
  p_resp_follows_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  p_resp_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
  p_perm_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && permVec == '0) |=> !respAllow);
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);
  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(parityEn));
  p_no_disable_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!parityEn && !regWrEn) |=> $stable(disabledVec));
  p_write_reenables_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr < IDX_W'(NUM_ENTRIES)) |=> !disabledVec[$past(regAddr)]);
  p_scan_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> $stable(scanIdx));
  p_scan_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    scanIdx < IDX_W'(NUM_ENTRIES));
endmodule

bind idFilter idFilterChk #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .permVec(permVec), .parityEn(parityEn), .irqClr(irqClr), .irq(irq),
  .reqValid(reqValid), .respValid(respValid), .respAllow(respAllow),
  .scanIdx(scanIdx), .disabledVec(disabledVec)
);

// File: tb/idFilter_test.sv
module idFilter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [N-1:0] permVec = '0;
  logic        parityEn = 1'b0, irqClr = 1'b0;
  logic        irq;
  logic        reqValid = 1'b0;
  logic [9:0]  reqId = '0;
  logic        reqWrite = 1'b0;
  logic        respValid, respAllow;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  idFilter uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .permVec(permVec), .parityEn(parityEn), .irqClr(irqClr), .irq(irq),
    .reqValid(reqValid), .reqId(reqId), .reqWrite(reqWrite),
    .respValid(respValid), .respAllow(respAllow)
  );

  function automatic logic [31:0] mkEntry(logic [9:0] id, logic [9:0] mask,
                                          logic ro, logic badPar);
    logic p;
    p = ^{ro, mask, id} ^ badPar;
    return {p, ro, 4'b0, mask, 6'b0, id};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(logic [4:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(logic [4:0] a, logic [31:0] exp, string tag);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    chk(tag, regRdData, exp);
  endtask

  // driver: push expectation, present one request cycle
  task automatic sendReq(logic [9:0] id, logic wr, logic exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    reqValid = 1'b1; reqId = id; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: compare each decision against the scoreboard
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: unexpected response actual 1 expected 0");
      end else begin
        logic e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, {31'b0, respAllow}, {31'b0, e});
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 respValid after reset", {31'b0, respValid}, 0);
    readCheck(5'd7, 32'h0, "R1 entry reads zero");

    // R2 readback with reserved bits and out-of-range index
    writeReg(5'd0, mkEntry(10'h155, 10'h3FF, 1'b0, 1'b0) | 32'h0800_1000);
    readCheck(5'd0, mkEntry(10'h155, 10'h3FF, 1'b0, 1'b0), "R2 readback reserved zero");
    writeReg(5'd25, 32'hFFFF_FFFF);
    readCheck(5'd25, 32'h0, "R2 out of range reads zero");

    // R4 permission gating, R3 exact match
    sendReq(10'h155, 1'b0, 1'b0, "R4 perm zero denies");
    permVec = 20'h00001;
    sendReq(10'h155, 1'b0, 1'b1, "R3 exact match allowed");
    sendReq(10'h154, 1'b0, 1'b0, "R3 one bit off denied");

    // R3 don't-care bits, R5 read-only
    writeReg(5'd1, mkEntry(10'h2A0, 10'h3F0, 1'b1, 1'b0));
    permVec = 20'h00003;
    sendReq(10'h2A7, 1'b0, 1'b1, "R3 masked bits ignored");
    sendReq(10'h2A7, 1'b1, 1'b0, "R5 read-only denies write");
    sendReq(10'h2B7, 1'b0, 1'b0, "R3 unmasked bit differs");

    // R6 any permitting entry allows
    writeReg(5'd2, mkEntry(10'h2A0, 10'h3F0, 1'b0, 1'b0));
    permVec = 20'h00007;
    sendReq(10'h2A9, 1'b1, 1'b1, "R6 second entry permits write");
    permVec = 20'h00003;
    sendReq(10'h2A9, 1'b1, 1'b0, "R6 only read-only entry left");
    waitCycles(1);
    chk("R7 no response when idle", {31'b0, respValid}, 0);

    // R9 parity check off
    writeReg(5'd3, mkEntry(10'h0F0, 10'h3FF, 1'b0, 1'b1));
    permVec = 20'h0000B;
    waitCycles(25);
    chk("R9 no irq when disabled", {31'b0, irq}, 0);
    sendReq(10'h0F0, 1'b1, 1'b1, "R9 bad entry still matches");

    // R8 parity check on
    parityEn = 1'b1;
    waitCycles(25);
    chk("R8 irq raised", {31'b0, irq}, 1);
    sendReq(10'h0F0, 1'b1, 1'b0, "R8 faulty entry disabled");
    sendReq(10'h155, 1'b1, 1'b1, "R8 good entry still matches");

    // R10 sticky and clear
    waitCycles(5);
    chk("R10 irq sticky", {31'b0, irq}, 1);
    irqClr = 1'b1;
    waitCycles(1);
    irqClr = 1'b0;
    chk("R10 irq cleared", {31'b0, irq}, 0);
    waitCycles(25);
    chk("R10 disabled entry no new irq", {31'b0, irq}, 0);

    // R11 rewrite with valid parity
    writeReg(5'd3, mkEntry(10'h0F0, 10'h3FF, 1'b0, 1'b0));
    waitCycles(25);
    chk("R11 no irq after valid rewrite", {31'b0, irq}, 0);
    sendReq(10'h0F0, 1'b1, 1'b1, "R11 entry matches again");

    waitCycles(3);
    chk("R7 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule